// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the phase and index signals of an incremental rotary or linear encoder into a signed-free position count of parameterised width, plus a direction flag. Every edge of either phase moves the count by one. The phases can be exchanged or inverted before decoding. A reference mark input can reload the count when the phases are in a chosen state. As an alternative, the count can be confined to a programmable range, from zero up to a ceiling value.

Each input first passes through its own glitch filter. When the filter is on, a new level reaches the decoder only after it has been held for a programmed number of core clocks. The block reports single-cycle event pulses for four conditions: a change of counting direction, a wrap at either end of the range, and an illegal phase transition. All inputs are assumed to be synchronous to `clk`. The configuration pins are meant to be changed only while `en` is low.

Top module: `qenc_counter`

## Requirements
- R1: After the filter, swap and inversion, the decoder treats the phase sequence {A,B} = 00, 10, 11, 01 as forward. Each step through it adds one to `count`, and each step backward subtracts one. Both edges of both phases count. In index mode the count wraps freely at the width limit.
- R2: With `swap_ab` high, the A and B inputs trade roles before decoding, so the same pin sequence counts in the opposite direction.
- R3: `inv_a`, `inv_b` and `inv_idx` invert their pin before filtering. With `inv_idx` high, the falling edge of `pin_idx` is the index edge. Inverting exactly one phase reverses the counting direction.
- R4: In index mode (`ceil_mode` = 0), a rising index edge loads `preset` into `count`, but only when the decoded phases equal `idx_gate`, with bit 1 giving the required A level and bit 0 the required B level. If the phases do not match, the count is left unchanged. In ceiling mode (`ceil_mode` = 1) the index has no effect on the count.
- R5: In ceiling mode, a forward step taken while `count` is at or above `ceiling` sets `count` to 0 and pulses `ev_rst_up` for one cycle.
- R6: In ceiling mode, a backward step taken while `count` is 0 loads `ceiling` and pulses `ev_rst_dn` for one cycle.
- R7: With `flt_en` high, a new input level reaches the decoder only after it has been sampled unchanged for `flt_len` + 2 consecutive clocks; a shorter pulse is dropped. With `flt_en` low, every level is passed through.
- R8: `dir_up` reads 1 after reset. Each step in the opposite direction to `dir_up` flips it and pulses `ev_dir` for one cycle.
- R9: If A and B change in the same sample, `count` is left unchanged. `ev_perr` pulses only if `perr_en` is high.
- R10: While `en` is low, `count` and `dir_up` hold and no event pulses. The decoder still tracks the phase levels, so raising `en` does not produce a step.
- R11: Reset clears `count` and all event outputs and sets `dir_up`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counting and event enable |
| ceil_mode | input | 1 | 0 = index preset mode, 1 = ceiling range mode |
| ceiling | input | CNT_W | Top of the count range in ceiling mode |
| preset | input | CNT_W | Value loaded on a qualified index |
| idx_gate | input | 2 | Required phase state for index: bit 1 = A, bit 0 = B |
| swap_ab | input | 1 | Exchange the A and B phases |
| inv_a | input | 1 | Invert pin A |
| inv_b | input | 1 | Invert pin B |
| inv_idx | input | 1 | Invert the index pin |
| perr_en | input | 1 | Enable phase error events |
| flt_en | input | 1 | Enable the glitch filters |
| flt_len | input | FLT_W | Filter window minus two, in clocks |
| pin_a | input | 1 | Phase A from the encoder |
| pin_b | input | 1 | Phase B from the encoder |
| pin_idx | input | 1 | Index mark from the encoder |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | 1 when the last step was forward |
| ev_dir | output | 1 | Direction change pulse |
| ev_rst_up | output | 1 | Wrap from ceiling to 0 pulse |
| ev_rst_dn | output | 1 | Wrap from 0 to ceiling pulse |
| ev_perr | output | 1 | Illegal phase transition pulse |

## Verification
For ceilings 1 through 4, the bench sweeps forward and backward steps across both wrap points and checks the count after every step. A design off by one in its ceiling compare would stop one value early or late, and would also miss or double the wrap pulses. All sixteen pairings of index gate and phase state are exercised, so a gate with its bit order swapped would reload the count in the wrong quadrant. Glitches of every length around the filter window are applied for several window settings; a filter that accepts a level one clock early or late shows up as a wrong direction-change count. Double-phase jumps, disabled counting and swapped or inverted phases are checked to confirm they neither move the count nor raise stray events.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int NUM_IN = 3;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int CH_IDX = 2;

  typedef enum logic {
    MODE_INDEX = 1'b0,
    MODE_CEIL  = 1'b1
  } qenc_mode_e;
endpackage

// File: rtl/qenc_filter.sv
module qenc_filter #(
  parameter int FLT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flt_en,
  input  logic [FLT_W-1:0] flt_len,
  input  logic             din,
  output logic             dout
);
  localparam int CW = FLT_W + 1;

  logic [CW-1:0] run_q;
  logic [CW-1:0] limit;

  assign limit = {1'b0, flt_len} + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (!flt_en) begin
      dout  <= din;
      run_q <= '0;
    end else if (din == dout) begin
      run_q <= '0;
    end else if (run_q == limit) begin
      dout  <= din;
      run_q <= '0;
    end else begin
      run_q <= run_q + CW'(1);
    end
  end

  // R7
  hold_when_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_en && din == dout) |=> $stable(dout));
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ph_a,
  input  logic       ph_b,
  input  logic       idx,
  input  logic [1:0] idx_gate,
  output logic       step_up,
  output logic       step_dn,
  output logic       ph_err,
  output logic       idx_hit
);
  logic prev_a, prev_b, prev_idx;
  logic chg_a, chg_b, single, fwd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_a   <= 1'b0;
      prev_b   <= 1'b0;
      prev_idx <= 1'b0;
    end else begin
      prev_a   <= ph_a;
      prev_b   <= ph_b;
      prev_idx <= idx;
    end
  end

  assign chg_a   = ph_a ^ prev_a;
  assign chg_b   = ph_b ^ prev_b;
  assign single  = chg_a ^ chg_b;
  assign fwd     = chg_a ? (ph_a != ph_b) : (ph_a == ph_b);
  assign step_up = single & fwd;
  assign step_dn = single & ~fwd;
  assign ph_err  = chg_a & chg_b;
  assign idx_hit = idx & ~prev_idx & ({ph_a, ph_b} == idx_gate);

  // R9
  err_excl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_err |-> !(step_up || step_dn));
endmodule

// File: rtl/qenc_position.sv
module qenc_position #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ceil_mode,
  input  logic [CNT_W-1:0] ceiling,
  input  logic [CNT_W-1:0] preset,
  input  logic             perr_en,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             ph_err,
  input  logic             idx_hit,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             ev_dir,
  output logic             ev_rst_up,
  output logic             ev_rst_dn,
  output logic             ev_perr
);
  import qenc_pkg::*;

  qenc_mode_e mode;
  assign mode = qenc_mode_e'(ceil_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      dir_up    <= 1'b1;
      ev_dir    <= 1'b0;
      ev_rst_up <= 1'b0;
      ev_rst_dn <= 1'b0;
      ev_perr   <= 1'b0;
    end else begin
      ev_dir    <= 1'b0;
      ev_rst_up <= 1'b0;
      ev_rst_dn <= 1'b0;
      ev_perr   <= 1'b0;
      if (en) begin
        if (mode == MODE_INDEX && idx_hit) begin
          count <= preset;
        end else if (step_up) begin
          if (mode == MODE_CEIL && count >= ceiling) begin
            count     <= '0;
            ev_rst_up <= 1'b1;
          end else begin
            count <= count + CNT_W'(1);
          end
        end else if (step_dn) begin
          if (mode == MODE_CEIL && count == '0) begin
            count     <= ceiling;
            ev_rst_dn <= 1'b1;
          end else begin
            count <= count - CNT_W'(1);
          end
        end
        if ((step_up && !dir_up) || (step_dn && dir_up)) begin
          dir_up <= step_up;
          ev_dir <= 1'b1;
        end
        if (ph_err && perr_en) ev_perr <= 1'b1;
      end
    end
  end

  // R10
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(count) && !ev_dir && !ev_perr));
  // R5
  wrap_up_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rst_up |-> count == '0);
  // R6
  wrap_dn_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rst_dn |-> count == $past(ceiling));
  // R9
  err_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_perr |-> $stable(count));
  // R8
  dir_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir |-> dir_up != $past(dir_up));
  // R5
  events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rst_up, ev_rst_dn, ev_perr}));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CNT_W = 32,
  parameter int FLT_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ceil_mode,
  input  logic [CNT_W-1:0] ceiling,
  input  logic [CNT_W-1:0] preset,
  input  logic [1:0]       idx_gate,
  input  logic             swap_ab,
  input  logic             inv_a,
  input  logic             inv_b,
  input  logic             inv_idx,
  input  logic             perr_en,
  input  logic             flt_en,
  input  logic [FLT_W-1:0] flt_len,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             pin_idx,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             ev_dir,
  output logic             ev_rst_up,
  output logic             ev_rst_dn,
  output logic             ev_perr
);
  import qenc_pkg::*;

  logic [NUM_IN-1:0] pol_in;
  logic [NUM_IN-1:0] clean;
  logic ph_a, ph_b;
  logic step_up, step_dn, ph_err, idx_hit;

  assign pol_in[CH_A]   = pin_a ^ inv_a;
  assign pol_in[CH_B]   = pin_b ^ inv_b;
  assign pol_in[CH_IDX] = pin_idx ^ inv_idx;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_flt
    qenc_filter #(.FLT_W(FLT_W)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .flt_en  (flt_en),
      .flt_len (flt_len),
      .din     (pol_in[i]),
      .dout    (clean[i])
    );
  end

  assign ph_a = swap_ab ? clean[CH_B] : clean[CH_A];
  assign ph_b = swap_ab ? clean[CH_A] : clean[CH_B];

  qenc_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_a     (ph_a),
    .ph_b     (ph_b),
    .idx      (clean[CH_IDX]),
    .idx_gate (idx_gate),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .ph_err   (ph_err),
    .idx_hit  (idx_hit)
  );

  qenc_position #(.CNT_W(CNT_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ceil_mode (ceil_mode),
    .ceiling   (ceiling),
    .preset    (preset),
    .perr_en   (perr_en),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .ph_err    (ph_err),
    .idx_hit   (idx_hit),
    .count     (count),
    .dir_up    (dir_up),
    .ev_dir    (ev_dir),
    .ev_rst_up (ev_rst_up),
    .ev_rst_dn (ev_rst_dn),
    .ev_perr   (ev_perr)
  );
endmodule

// File: tb/test_qenc_counter.sv
`timescale 1ns/1ps
module test_qenc_counter;
  localparam int CNT_W = 32;
  localparam int FLT_W = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ceil_mode = 1'b1;
  logic [CNT_W-1:0] ceiling = '1, preset = '0;
  logic [1:0] idx_gate = 2'd0;
  logic swap_ab = 0, inv_a = 0, inv_b = 0, inv_idx = 0, perr_en = 0, flt_en = 0;
  logic [FLT_W-1:0] flt_len = '0;
  logic pin_a = 0, pin_b = 0, pin_idx = 0;
  logic [CNT_W-1:0] count;
  logic dir_up, ev_dir, ev_rst_up, ev_rst_dn, ev_perr;

  int checks = 0, errors = 0;
  int n_dir = 0, n_up = 0, n_dn = 0, n_perr = 0;
  int ph = 0;

  always #10 clk = ~clk;

  qenc_counter #(.CNT_W(CNT_W), .FLT_W(FLT_W)) i_qenc_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .ceil_mode(ceil_mode), .ceiling(ceiling),
    .preset(preset), .idx_gate(idx_gate), .swap_ab(swap_ab), .inv_a(inv_a),
    .inv_b(inv_b), .inv_idx(inv_idx), .perr_en(perr_en), .flt_en(flt_en),
    .flt_len(flt_len), .pin_a(pin_a), .pin_b(pin_b), .pin_idx(pin_idx),
    .count(count), .dir_up(dir_up), .ev_dir(ev_dir), .ev_rst_up(ev_rst_up),
    .ev_rst_dn(ev_rst_dn), .ev_perr(ev_perr)
  );

  always @(negedge clk) begin
    if (ev_dir) n_dir++;
    if (ev_rst_up) n_up++;
    if (ev_rst_dn) n_dn++;
    if (ev_perr) n_perr++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_ph();
    pin_a = (ph == 1 || ph == 2);
    pin_b = (ph == 2 || ph == 3);
  endtask

  task automatic step(input bit up, input int hold);
    ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
    drive_ph();
    cyc(hold);
  endtask

  task automatic steps(input int n, input bit up);
    for (int i = 0; i < n; i++) step(up, 3);
  endtask

  task automatic reconfig_off();
    en = 1'b0;
    cyc(2);
  endtask

  task automatic reconfig_on();
    cyc(4);
    en = 1'b1;
    cyc(1);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] prior;
    logic [31:0] exp;
    int up0, dn0, d0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R11 reset state
    chk("R11 count", count, 0);
    chk("R11 dir_up", dir_up, 1);
    chk("R11 events", {ev_dir, ev_rst_up, ev_rst_dn, ev_perr}, 0);

    en = 1'b1;
    cyc(1);
    // R1 forward stepping, each step checked
    for (int i = 1; i <= 20; i++) begin
      step(1, 3);
      chk("R1 up", count, i);
    end
    chk("R8 no dir event going up", n_dir, 0);
    for (int i = 1; i <= 8; i++) begin
      step(0, 3);
      chk("R1 down", count, 20 - i);
    end
    chk("R8 dir event", n_dir, 1);
    chk("R8 dir_up low", dir_up, 0);
    step(1, 3);
    chk("R8 dir back", n_dir, 2);
    chk("R8 dir_up high", dir_up, 1);
    chk("R1 after reversal", count, 13);

    // R2 swap
    reconfig_off(); swap_ab = 1; reconfig_on();
    steps(5, 1);
    chk("R2 swapped counts down", count, 8);
    reconfig_off(); swap_ab = 0; reconfig_on();

    // R3 phase inversion
    reconfig_off(); inv_a = 1; reconfig_on();
    steps(4, 1);
    chk("R3 inv_a reverses", count, 4);
    reconfig_off(); inv_a = 0; inv_b = 1; reconfig_on();
    steps(3, 1);
    chk("R3 inv_b reverses", count, 1);
    reconfig_off(); inv_b = 0; reconfig_on();

    // R10 disabled
    d0 = n_dir;
    en = 1'b0;
    steps(3, 0);
    perr_en = 1; ph = (ph + 2) % 4; drive_ph(); cyc(3); perr_en = 0;
    chk("R10 count held", count, 1);
    chk("R10 no events", n_dir - d0 + n_perr, 0);
    en = 1'b1;
    cyc(3);
    chk("R10 no step on enable", count, 1);

    // R5 R6 ceiling sweep
    for (int c = 1; c <= 4; c++) begin
      reconfig_off(); ceiling = c; reconfig_on();
      prior = count;
      up0 = n_up;
      for (int i = 0; i < 3 * (c + 1) + 1; i++) begin
        if (prior >= c) begin prior = 0; up0++; end
        else prior++;
        step(1, 3);
        chk("R5 ceiling up", count, prior);
      end
      chk("R5 wrap up events", n_up, up0);
      dn0 = n_dn;
      for (int i = 0; i < 3 * (c + 1) + 1; i++) begin
        if (prior == 0) begin prior = c; dn0++; end
        else prior--;
        step(0, 3);
        chk("R6 ceiling down", count, prior);
      end
      chk("R6 wrap down events", n_dn, dn0);
    end
    reconfig_off(); ceiling = '1; reconfig_on();

    // R9 phase error
    prior = count;
    perr_en = 1;
    ph = (ph + 2) % 4; drive_ph(); cyc(3);
    chk("R9 count held", count, prior);
    chk("R9 event", n_perr, 1);
    perr_en = 0;
    ph = (ph + 2) % 4; drive_ph(); cyc(3);
    chk("R9 count held unreported", count, prior);
    chk("R9 no event when off", n_perr, 1);

    // R4 index gating, all gate/state pairs
    reconfig_off(); ceil_mode = 0; reconfig_on();
    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s < 4; s++) begin
        int tgt;
        tgt = (s == 0) ? 0 : (s == 2) ? 1 : (s == 3) ? 2 : 3;
        idx_gate = g[1:0];
        preset = 32'hA000_0000 + 32'(g * 16 + s);
        while (ph != tgt) step(1, 3);
        prior = count;
        pin_idx = 1; cyc(3); pin_idx = 0; cyc(3);
        exp = (g == s) ? preset : prior;
        chk("R4 index gate", count, exp);
      end
    end
    // R3 inverted index: pin falling edge qualifies
    reconfig_off(); inv_idx = 1; idx_gate = (ph == 0) ? 2'd0 : (ph == 1) ? 2'd2 : (ph == 2) ? 2'd3 : 2'd1;
    preset = 32'h0000_5A5A; pin_idx = 1; reconfig_on();
    steps(2, 1); steps(2, 0);
    pin_idx = 0; cyc(3);
    chk("R3 index inverted", count, 32'h0000_5A5A);
    pin_idx = 1; cyc(3);
    // R4 ceiling mode ignores index
    reconfig_off(); ceil_mode = 1; reconfig_on();
    prior = count;
    pin_idx = 0; cyc(3); pin_idx = 1; cyc(3);
    chk("R4 index ignored in ceiling mode", count, prior);
    reconfig_off(); inv_idx = 0; pin_idx = 0; reconfig_on();

    // R7 filter window sweep
    flt_en = 1;
    for (int k = 0; k < 3; k++) begin
      int len;
      len = (k == 0) ? 0 : (k == 1) ? 2 : 5;
      reconfig_off(); flt_len = FLT_W'(len); reconfig_on();
      cyc(len + 4);
      for (int n = 1; n <= len + 3; n++) begin
        step(1, len + 8);
        prior = count;
        d0 = n_dir;
        step(1, n);
        ph = (ph + 3) % 4; drive_ph(); cyc(len + 8);
        chk("R7 glitch dir events", n_dir - d0, (n >= len + 2) ? 1 : 0);
        chk("R7 glitch net count", count, prior);
      end
    end
    reconfig_off(); flt_en = 0; reconfig_on();
    step(1, 3);
    d0 = n_dir;
    step(1, 1);
    ph = (ph + 3) % 4; drive_ph(); cyc(4);
    chk("R7 bypass passes 1-cycle pulse", n_dir - d0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule